// File: doc/BRIEF.md
# Bit-band alias access bridge

This bridge sits between a simple memory-mapped bus master and a downstream memory port. Each port uses a valid/ready handshake. Most accesses go straight through. Two 32 MB alias windows get special treatment. In these windows every 32-bit alias word stands for one bit of a target memory region. A read of an alias word returns that single bit as 0 or 1. A write of an alias word sets or clears that bit, depending on bit 0 of the write data. The bridge does this as an indivisible read-modify-write of the target location.

The access size changes both the target alignment and the range of the bit index. Software can therefore touch one bit of a byte, a halfword or a word at the same physical location. The downstream bus is little-endian. Byte lanes are selected by address bits [1:0], so the selected bit is placed in the lane that the aligned target address names. Only one upstream request is in flight at a time. The bridge raises the upstream ready for one cycle when the whole sequence has finished.

Top module: `bitband_bridge`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle and drives `dn_valid` and `up_ready` low, including when the reset arrives in the middle of a transfer.
- R2: An address whose bits [31:25] match 0x2200_0000 (window 0) or 0x4200_0000 (window 1) is an alias access. Every other address is ordinary.
- R3: The alias target address is the window's region base (0x2000_0000 for window 0, 0x4000_0000 for window 1) ORed with alias address bits [24:5]. Size code 1 (halfword) clears target bit 0, and size code 2 (word) clears target bits [1:0]. Size code 0 is a byte access.
- R4: The bit index is alias address bits [6:2], limited to 3 bits for a byte, 4 bits for a halfword and 5 bits for a word.
- R5: An alias read makes exactly one downstream read of the target with the same size. It returns the selected bit in `up_rdata[0]`, with bits [31:1] zero.
- R6: An alias write reads the target and then writes it back with the same address and size. The selected bit equals `up_wdata[0]` and every other bit is unchanged.
- R7: The write-back of an alias write is requested in the cycle right after the read completes, with no other downstream transfer in between. `up_ready` stays low until the write-back completes.
- R8: Downstream data is little-endian. For a byte, the selected bit sits at data position 8*target[1:0] + index. For a halfword it sits at 16*target[1] + index. For a word it sits at the index itself.
- R9: An ordinary access makes exactly one downstream transfer with the same address, direction, size and write data. A read returns the downstream data unchanged.
- R10: While `dn_valid` is high and `dn_ready` is low, the downstream request (address, direction, size, data) holds stable.
- R11: `up_ready` is a one-cycle pulse per accepted request. `up_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid, held until up_ready |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data, lane-aligned |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_ready |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream completion pulse |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_size | output | 2 | Downstream access size |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |

## Verification
A wrong latched bit position or window choice shows up as a wrong downstream address or a wrong bit in memory. This is visible when the request completes, a few cycles after the upstream request. A sequencer stuck in or skipping its write phase shows as a missing or extra downstream transfer before `up_ready`. It can also show as a ready pulse that never arrives. Random mixes of sizes, windows and directions, plus the window edges, make sure each lane position and each decode path is hit.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_RD,
    ST_WR,
    ST_RESP
  } seq_state_e;

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int POS_W  = 5,
  parameter int NWIN   = 2,
  parameter int WIN_LG = 25,
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][ADDR_W-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [POS_W-1:0]  bit_pos
);

  localparam int SHIFT = POS_W;
  localparam int HI_W  = ADDR_W - WIN_LG;

  logic [NWIN-1:0]              win_hit;
  logic [NWIN-1:0][ADDR_W-1:0]  win_tgt;
  logic [ADDR_W-1:0]            raw_tgt;
  logic [POS_W-1:0]             idx;

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      assign win_hit[w] = (addr[ADDR_W-1:WIN_LG] == ALIAS_BASE[w][ADDR_W-1:WIN_LG]);
      assign win_tgt[w] = TGT_BASE[w] |
                          {{(HI_W + SHIFT){1'b0}}, addr[WIN_LG-1:SHIFT]};
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    raw_tgt = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit     = 1'b1;
        raw_tgt = win_tgt[i];
      end
    end
  end

  assign idx = addr[POS_W+1:2];

  always_comb begin
    tgt_addr = raw_tgt;
    bit_pos  = idx;
    case (size)
      SZ_BYTE: begin
        bit_pos = {raw_tgt[1:0], idx[2:0]};
      end
      SZ_HALF: begin
        tgt_addr[0] = 1'b0;
        bit_pos     = {raw_tgt[1], idx[3:0]};
      end
      default: begin
        tgt_addr[1:0] = 2'b00;
        bit_pos       = idx;
      end
    endcase
  end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [POS_W-1:0]  pos,
  input  logic              new_bit,
  output logic              bit_out,
  output logic [DATA_W-1:0] word_out
);

  logic [DATA_W-1:0] mask;

  assign mask     = {{(DATA_W-1){1'b0}}, 1'b1} << pos;
  assign bit_out  = |(word_in & mask);
  assign word_out = new_bit ? (word_in | mask) : (word_in & ~mask);

endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  input  logic              dec_hit,
  input  logic [ADDR_W-1:0] dec_tgt,
  input  logic [POS_W-1:0]  dec_pos,
  output logic [POS_W-1:0]  pos_q,
  output logic              wbit_q,
  input  logic              lane_bit,
  input  logic [DATA_W-1:0] lane_word,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);

  seq_state_e st;
  logic       alias_q;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      up_ready <= 1'b0;
      up_rdata <= '0;
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_size  <= '0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      alias_q  <= 1'b0;
      wr_q     <= 1'b0;
      pos_q    <= '0;
      wbit_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          up_ready <= 1'b0;
          if (up_valid) begin
            alias_q  <= dec_hit;
            wr_q     <= up_write;
            pos_q    <= dec_pos;
            wbit_q   <= up_wdata[0];
            dn_size  <= up_size;
            dn_valid <= 1'b1;
            if (dec_hit) begin
              dn_addr  <= dec_tgt;
              dn_write <= 1'b0;
              dn_wdata <= '0;
              st       <= ST_RD;
            end else begin
              dn_addr  <= up_addr;
              dn_write <= up_write;
              dn_wdata <= up_wdata;
              st       <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            up_rdata <= wr_q ? '0 : dn_rdata;
            up_ready <= 1'b1;
            st       <= ST_RESP;
          end
        end
        ST_RD: begin
          if (dn_ready) begin
            if (wr_q) begin
              dn_wdata <= lane_word;
              dn_write <= 1'b1;
              st       <= ST_WR;
            end else begin
              dn_valid <= 1'b0;
              up_rdata <= {{(DATA_W-1){1'b0}}, lane_bit};
              up_ready <= 1'b1;
              st       <= ST_RESP;
            end
          end
        end
        ST_WR: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            dn_write <= 1'b0;
            up_rdata <= '0;
            up_ready <= 1'b1;
            st       <= ST_RESP;
          end
        end
        default: begin
          up_ready <= 1'b0;
          st       <= ST_IDLE;
        end
      endcase
    end
  end

  // R10: a pending downstream request does not move
  p_dn_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)
                                 && $stable(dn_size) && $stable(dn_wdata)));

  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready);

  // R7: write-back follows the read at once, same address and size
  p_rmw_back2back_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && dn_ready && wr_q) |=>
      (dn_valid && dn_write && $stable(dn_addr) && $stable(dn_size)));

  // R7: no upstream completion while the write-back is pending
  p_no_early_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR) |-> !up_ready);

  // R5: an alias read returns only bit 0
  p_alias_rdata_r5: assert property (@(posedge clk) disable iff (rst)
    (up_ready && alias_q && !wr_q) |-> (up_rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NWIN   = 2,
  parameter int WIN_LG = 25,
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][ADDR_W-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);

  localparam int POS_W = $clog2(DATA_W);

  logic              dec_hit;
  logic [ADDR_W-1:0] dec_tgt;
  logic [POS_W-1:0]  dec_pos;
  logic [POS_W-1:0]  pos_q;
  logic              wbit_q;
  logic              lane_bit;
  logic [DATA_W-1:0] lane_word;

  bb_window_decode #(
    .ADDR_W(ADDR_W), .POS_W(POS_W), .NWIN(NWIN), .WIN_LG(WIN_LG),
    .ALIAS_BASE(ALIAS_BASE), .TGT_BASE(TGT_BASE)
  ) u_dec (
    .addr(up_addr), .size(up_size),
    .hit(dec_hit), .tgt_addr(dec_tgt), .bit_pos(dec_pos)
  );

  bb_bit_lane #(.DATA_W(DATA_W), .POS_W(POS_W)) u_lane (
    .word_in(dn_rdata), .pos(pos_q), .new_bit(wbit_q),
    .bit_out(lane_bit), .word_out(lane_word)
  );

  bb_rmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_write(up_write), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dec_hit(dec_hit), .dec_tgt(dec_tgt), .dec_pos(dec_pos),
    .pos_q(pos_q), .wbit_q(wbit_q),
    .lane_bit(lane_bit), .lane_word(lane_word),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
  );

endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;

  logic        clk = 1'b0;
  logic        rst;
  logic        up_valid, up_write;
  logic [1:0]  up_size;
  logic [31:0] up_addr, up_wdata;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_ready, dn_write;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bitband_bridge u0 (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_write(up_write), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
  );

  // Memory model and responder
  logic [31:0] mem [0:1023];
  int          tx_total;
  int unsigned lat;
  logic [31:0] lg_addr  [0:3];
  logic        lg_wr    [0:3];
  logic [1:0]  lg_size  [0:3];
  logic [31:0] lg_wdata [0:3];

  function automatic logic [31:0] wmerge(logic [31:0] old, logic [31:0] nw,
                                         logic [31:0] a, logic [1:0] sz);
    logic [31:0] m;
    if (sz == 2'd0)      m = 32'hFF << (8 * a[1:0]);
    else if (sz == 2'd1) m = 32'hFFFF << (16 * a[1]);
    else                 m = 32'hFFFF_FFFF;
    return (old & ~m) | (nw & m);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      dn_ready <= 1'b0;
      dn_rdata <= '0;
      lat      <= 0;
      tx_total <= 0;
      for (int i = 0; i < 1024; i++) mem[i] <= (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    end else if (dn_ready) begin
      dn_ready <= 1'b0;
    end else if (dn_valid) begin
      if (lat == 0) begin
        dn_ready <= 1'b1;
        lat      <= $urandom % 3;
        if (dn_write) mem[dn_addr[11:2]] <= wmerge(mem[dn_addr[11:2]], dn_wdata, dn_addr, dn_size);
        else          dn_rdata <= mem[dn_addr[11:2]];
        lg_addr[tx_total % 4]  <= dn_addr;
        lg_wr[tx_total % 4]    <= dn_write;
        lg_size[tx_total % 4]  <= dn_size;
        lg_wdata[tx_total % 4] <= dn_wdata;
        tx_total <= tx_total + 1;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // R10 monitor: pending request must hold
  int          hold_viol = 0;
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr;
  logic        pend_wr;
  always @(posedge clk) begin
    if (!rst && pend_q && (dn_addr !== pend_addr || dn_write !== pend_wr || !dn_valid))
      hold_viol <= hold_viol + 1;
    pend_q    <= !rst && dn_valid && !dn_ready;
    pend_addr <= dn_addr;
    pend_wr   <= dn_write;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model
  function automatic bit ref_alias(logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  function automatic logic [31:0] ref_tgt(logic [31:0] a, logic [1:0] sz);
    logic [31:0] t;
    t = ((a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) | ((a & 32'h01FF_FFFF) >> 5);
    if (sz == 2'd1)      t = t & ~32'd1;
    else if (sz == 2'd2) t = t & ~32'd3;
    return t;
  endfunction

  function automatic int ref_pos(logic [31:0] a, logic [1:0] sz);
    logic [31:0] t;
    t = ref_tgt(a, sz);
    if (sz == 2'd0)      return 8 * int'(t & 3) + int'((a >> 2) & 7);
    else if (sz == 2'd1) return 16 * int'((t >> 1) & 1) + int'((a >> 2) & 15);
    else                 return int'((a >> 2) & 31);
  endfunction

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    int          t0, n, wait_cyc, p;
    bit          al;
    logic [31:0] tg, old, rd, expw;
    al = ref_alias(a);
    tg = al ? ref_tgt(a, sz) : a;
    p  = al ? ref_pos(a, sz) : 0;
    t0 = tx_total;
    old = mem[tg[11:2]];
    up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = wd;
    wait_cyc = 0;
    do begin
      @(negedge clk);
      wait_cyc++;
    end while (!up_ready && wait_cyc < 60);
    rd = up_rdata;
    up_valid = 1'b0;
    if (!up_ready) begin
      chk(1'b0, "R11 watchdog no up_ready", 32'd0, 32'd1);
      return;
    end
    n = tx_total - t0;
    if (al && !wr) begin
      chk(n == 1, "R5 one downstream read", n, 1);
      chk(lg_addr[t0 % 4] == tg && !lg_wr[t0 % 4], "R3 alias read target", lg_addr[t0 % 4], tg);
      chk(lg_size[t0 % 4] == sz, "R5 alias size kept", lg_size[t0 % 4], sz);
      chk(rd == {31'd0, old[p]}, "R4 R8 alias read bit", rd, {31'd0, old[p]});
    end else if (al) begin
      expw = wd[0] ? (old | (32'd1 << p)) : (old & ~(32'd1 << p));
      chk(n == 2, "R7 two downstream transfers", n, 2);
      chk(!lg_wr[t0 % 4] && lg_wr[(t0 + 1) % 4], "R6 read then write", {lg_wr[t0 % 4], lg_wr[(t0 + 1) % 4]}, 2'b01);
      chk(lg_addr[t0 % 4] == tg && lg_addr[(t0 + 1) % 4] == tg, "R3 alias write target", lg_addr[(t0 + 1) % 4], tg);
      chk(lg_size[(t0 + 1) % 4] == sz, "R6 write-back size", lg_size[(t0 + 1) % 4], sz);
      chk(mem[tg[11:2]] == expw, "R6 R8 bit updated", mem[tg[11:2]], expw);
    end else begin
      chk(n == 1, "R9 one downstream transfer", n, 1);
      chk(lg_addr[t0 % 4] == a && lg_wr[t0 % 4] == wr && lg_size[t0 % 4] == sz,
          "R2 R9 forwarded unchanged", lg_addr[t0 % 4], a);
      if (wr) chk(lg_wdata[t0 % 4] == wd, "R9 write data", lg_wdata[t0 % 4], wd);
      else    chk(rd == old, "R9 read data", rd, old);
    end
    @(negedge clk);
    chk(!up_ready, "R11 ready single pulse", up_ready, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [1:0]  sz;
    int          r;
    void'($urandom(32'd2024));
    rst = 1'b1; up_valid = 1'b0; up_write = 1'b0; up_size = 2'd0;
    up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!dn_valid && !up_ready, "R1 reset state", {dn_valid, up_ready}, 0);

    // Directed window edges (R2)
    access(1'b0, 32'h21FF_FFFC, 2'd2, 0);
    access(1'b0, 32'h2200_0000, 2'd2, 0);
    access(1'b0, 32'h23FF_FFFC, 2'd0, 0);
    access(1'b0, 32'h2400_0000, 2'd2, 0);
    access(1'b0, 32'h4200_0000, 2'd1, 0);
    access(1'b1, 32'h43FF_FFFC, 2'd2, 32'd1);
    access(1'b1, 32'h41FF_FFF0, 2'd2, 32'hDEAD_BEEF);
    // Lane placement for each size (R8)
    for (int k = 0; k < 32; k++) begin
      access(1'b1, 32'h2200_0000 | (k << 2) | (32'd3 << 5), 2'd0, k[0]);
      access(1'b1, 32'h4200_0000 | (k << 2) | (32'd2 << 5), 2'd1, ~k[0]);
      access(1'b0, 32'h2200_0000 | (k << 2) | (32'd1 << 5), 2'd2, 0);
    end
    // Set then clear same bit (R6)
    access(1'b1, 32'h2200_0444, 2'd2, 32'hFFFF_FFFF);
    access(1'b0, 32'h2200_0444, 2'd2, 0);
    access(1'b1, 32'h2200_0444, 2'd2, 32'hFFFF_FFFE);
    access(1'b0, 32'h2200_0444, 2'd2, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      r  = $urandom % 5;
      sz = 2'($urandom % 3);
      a  = ($urandom % 32768);
      case (r)
        0: a = 32'h2200_0000 | a;
        1: a = 32'h4200_0000 | a;
        2: a = 32'h2000_0000 | a;
        3: a = 32'h4000_0000 | a;
        default: a = 32'h3000_0000 | a;
      endcase
      if (sz == 2'd1)      a[0]   = 1'b0;
      else if (sz == 2'd2) a[1:0] = 2'b00;
      access(1'($urandom % 2), a, sz, $urandom);
    end

    // Reset in the middle of an alias write (R1)
    up_valid = 1'b1; up_write = 1'b1; up_addr = 32'h4200_0100; up_size = 2'd2; up_wdata = 1;
    @(negedge clk);
    up_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!dn_valid && !up_ready, "R1 reset mid-transfer", {dn_valid, up_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    access(1'b0, 32'h4200_0100, 2'd2, 0);

    chk(hold_viol == 0, "R10 request held while pending", hold_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule